// File: doc/BRIEF.md
# Circular-Buffer Data Address Generator

This block produces operand addresses for indirect memory accesses. It keeps four pointer registers. Each pointer has its own length and base registers, and the block also holds four modify registers and one page register. On each access request the caller names one pointer and one modify register. The block issues a 24-bit address made of the 8-bit page followed by the 16-bit pointer, and it moves the chosen pointer by the signed modify value. Each request also says whether the pointer moves before the address is formed (pre-modify) or after it (post-modify).

If a pointer's length is zero, the pointer steps with plain 16-bit wraparound. If the length is non-zero, the step wraps inside the circular buffer that starts at the base and holds that many words. Wrapping only ever touches the 16-bit pointer, so a buffer never spills into a neighbouring page.

A second, complete register bank exists for fast context switches. A single swap input exchanges the active bank without copying anything. Software-style writes go through one register write port, and addresses come out through the access port. Bus arbitration and the memory itself are outside this block.

Top module: `circ_agen`

## Requirements
- R1: After reset, addrValid is 0, addrOut is 0 and activeBank is 0, and every pointer, modify, length, base and page register in both banks holds zero.
- R2: A write with wrEn=1 stores data into the active bank. wrKind selects the target: 0 is a pointer, 1 is a modify register, 2 is a length, 3 is a base, each chosen by wrIdx. Kind 4 is the page register and takes wrData[7:0]. Kinds 5 to 7 change nothing. A stored value is used by an access in the next cycle.
- R3: addrValid is 1 in the cycle after a cycle with reqValid=1, and 0 in the cycle after a cycle with reqValid=0. addrOut keeps its value while no access occurs.
- R4: In post-modify (reqPre=0), the low 16 bits of the issued address are the pointer value before the update.
- R5: In pre-modify (reqPre=1), the low 16 bits of the issued address are the updated pointer value. In both modes the pointer holds the updated value afterwards.
- R6: With length zero, the updated pointer is (pointer + modify) mod 2^16.
- R7: With a non-zero length, let s = pointer + signed modify. If s is below base, the result is s + length. If s is at or above base + length, the result is s - length. Otherwise the result is s.
- R8: addrOut[23:16] is the active page register and addrOut[15:0] is the pointer. A pointer step never changes the page bits.
- R9: bankSwap=1 toggles activeBank at the clock edge, and each bank keeps its values. A write or access in the same cycle as the swap uses the bank that was active before the swap.
- R10: If a write to a pointer and an access that updates the same pointer occur in the same cycle, the written value is what remains.
- R11: An access updates only the chosen pointer. The other pointers are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| wrKind | input | 3 | Register class selector (0 pointer, 1 modify, 2 length, 3 base, 4 page) |
| wrIdx | input | 2 | Register index within the class |
| wrData | input | 16 | Write data |
| reqValid | input | 1 | Access request |
| reqPtr | input | 2 | Pointer used by the access |
| reqMod | input | 2 | Modify register used by the access |
| reqPre | input | 1 | 1 = pre-modify, 0 = post-modify |
| bankSwap | input | 1 | Toggle the active register bank |
| addrValid | output | 1 | Issued address is valid |
| addrOut | output | 24 | Issued address {page, pointer} |
| activeBank | output | 1 | Currently active register bank |

## Verification
The bench builds the block with its default parameters: four pointers, a 16-bit pointer width and an 8-bit page. The full 16-bit pointer lets directed cases reach the top-of-page overflow within a few accesses, and that case shows the page bits stay fixed. Constrained random traffic uses short buffers near the low addresses with small signed modify values, so wraps past both the lower and upper ends of a buffer happen often. Swaps, writes and accesses are mixed in the same cycles, which covers the old-bank and write-wins cases.

// File: rtl/cagen_pkg.sv
package cagen_pkg;

  typedef enum logic [2:0] {
    KIND_PTR  = 3'd0,
    KIND_MOD  = 3'd1,
    KIND_LEN  = 3'd2,
    KIND_BASE = 3'd3,
    KIND_PAGE = 3'd4
  } regKind_e;

  typedef struct packed {
    logic wrPtr;
    logic wrMod;
    logic wrLen;
    logic wrBase;
    logic wrPage;
    logic accEn;
    logic preMode;
    logic bank;
  } dagStrobe_t;

endpackage

// File: rtl/cagen_ctrl.sv
module cagen_ctrl
  import cagen_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [2:0] wrKind,
  input  logic       reqValid,
  input  logic       reqPre,
  input  logic       bankSwap,
  output dagStrobe_t strobe,
  output logic       addrValid,
  output logic       activeBank
);

  logic bankQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bankQ     <= 1'b0;
      addrValid <= 1'b0;
    end else begin
      if (bankSwap) bankQ <= ~bankQ;
      addrValid <= reqValid;
    end
  end

  always_comb begin
    strobe         = '0;
    strobe.wrPtr   = wrEn && (wrKind == KIND_PTR);
    strobe.wrMod   = wrEn && (wrKind == KIND_MOD);
    strobe.wrLen   = wrEn && (wrKind == KIND_LEN);
    strobe.wrBase  = wrEn && (wrKind == KIND_BASE);
    strobe.wrPage  = wrEn && (wrKind == KIND_PAGE);
    strobe.accEn   = reqValid;
    strobe.preMode = reqPre;
    strobe.bank    = bankQ;
  end

  assign activeBank = bankQ;

  AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> addrValid); // R3
  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !addrValid); // R3
  AST_BANK_TOGGLE: assert property (@(posedge clk) disable iff (!rstN)
    bankSwap |=> (activeBank != $past(activeBank))); // R9
  AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !bankSwap |=> $stable(activeBank)); // R9

endmodule

// File: rtl/cagen_datapath.sv
module cagen_datapath
  import cagen_pkg::*;
#(
  parameter int NUM_PTR = 4,
  parameter int PTR_W   = 16,
  parameter int PAGE_W  = 8,
  localparam int IDX_W  = $clog2(NUM_PTR),
  localparam int ADDR_W = PAGE_W + PTR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  dagStrobe_t        strobe,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [PTR_W-1:0]  wrData,
  input  logic [IDX_W-1:0]  reqPtr,
  input  logic [IDX_W-1:0]  reqMod,
  output logic [ADDR_W-1:0] addrOut
);

  localparam int NUM_BANK = 2;
  localparam int SUM_W    = PTR_W + 2;

  logic [PTR_W-1:0]  ptrReg  [NUM_BANK][NUM_PTR];
  logic [PTR_W-1:0]  modReg  [NUM_BANK][NUM_PTR];
  logic [PTR_W-1:0]  lenReg  [NUM_BANK][NUM_PTR];
  logic [PTR_W-1:0]  baseReg [NUM_BANK][NUM_PTR];
  logic [PAGE_W-1:0] pageReg [NUM_BANK];

  logic [PTR_W-1:0]  curPtr, curMod, curLen, curBase, nextPtr;
  logic [PAGE_W-1:0] curPage;

  function automatic logic [PTR_W-1:0] wrapStep(
    input logic [PTR_W-1:0] p,
    input logic [PTR_W-1:0] m,
    input logic [PTR_W-1:0] b,
    input logic [PTR_W-1:0] l
  );
    logic signed [SUM_W-1:0] sum, lo, hi, lenS, res;
    sum  = $signed({2'b00, p}) + $signed({{2{m[PTR_W-1]}}, m});
    lo   = $signed({2'b00, b});
    lenS = $signed({2'b00, l});
    hi   = lo + lenS;
    res  = sum;
    if (l != '0) begin
      if (sum < lo)       res = sum + lenS;
      else if (sum >= hi) res = sum - lenS;
    end
    return res[PTR_W-1:0];
  endfunction

  always_comb begin
    curPtr  = ptrReg[strobe.bank][reqPtr];
    curMod  = modReg[strobe.bank][reqMod];
    curLen  = lenReg[strobe.bank][reqPtr];
    curBase = baseReg[strobe.bank][reqPtr];
    curPage = pageReg[strobe.bank];
    nextPtr = wrapStep(curPtr, curMod, curBase, curLen);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int b = 0; b < NUM_BANK; b++) begin
        for (int i = 0; i < NUM_PTR; i++) begin
          ptrReg[b][i]  <= '0;
          modReg[b][i]  <= '0;
          lenReg[b][i]  <= '0;
          baseReg[b][i] <= '0;
        end
        pageReg[b] <= '0;
      end
      addrOut <= '0;
    end else begin
      if (strobe.accEn) begin
        ptrReg[strobe.bank][reqPtr] <= nextPtr;
        addrOut <= {curPage, (strobe.preMode ? nextPtr : curPtr)};
      end
      // a write placed after the access update takes priority
      if (strobe.wrPtr)  ptrReg[strobe.bank][wrIdx]  <= wrData;
      if (strobe.wrMod)  modReg[strobe.bank][wrIdx]  <= wrData;
      if (strobe.wrLen)  lenReg[strobe.bank][wrIdx]  <= wrData;
      if (strobe.wrBase) baseReg[strobe.bank][wrIdx] <= wrData;
      if (strobe.wrPage) pageReg[strobe.bank]        <= wrData[PAGE_W-1:0];
    end
  end

  AST_PAGE_ON_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    strobe.accEn |=> (addrOut[ADDR_W-1:PTR_W] == $past(curPage))); // R8
  AST_POST_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.accEn && !strobe.preMode) |=> (addrOut[PTR_W-1:0] == $past(curPtr))); // R4
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.accEn |=> $stable(addrOut)); // R3

endmodule

// File: rtl/circ_agen.sv
module circ_agen
  import cagen_pkg::*;
#(
  parameter int NUM_PTR = 4,
  parameter int PTR_W   = 16,
  parameter int PAGE_W  = 8,
  localparam int IDX_W  = $clog2(NUM_PTR),
  localparam int ADDR_W = PAGE_W + PTR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [2:0]        wrKind,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [PTR_W-1:0]  wrData,
  input  logic              reqValid,
  input  logic [IDX_W-1:0]  reqPtr,
  input  logic [IDX_W-1:0]  reqMod,
  input  logic              reqPre,
  input  logic              bankSwap,
  output logic              addrValid,
  output logic [ADDR_W-1:0] addrOut,
  output logic              activeBank
);

  dagStrobe_t strobe;

  cagen_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .wrKind     (wrKind),
    .reqValid   (reqValid),
    .reqPre     (reqPre),
    .bankSwap   (bankSwap),
    .strobe     (strobe),
    .addrValid  (addrValid),
    .activeBank (activeBank)
  );

  cagen_datapath #(
    .NUM_PTR (NUM_PTR),
    .PTR_W   (PTR_W),
    .PAGE_W  (PAGE_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .wrIdx   (wrIdx),
    .wrData  (wrData),
    .reqPtr  (reqPtr),
    .reqMod  (reqMod),
    .addrOut (addrOut)
  );

endmodule

// File: tb/circ_agen_tb.sv
module circ_agen_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrKind = '0;
  logic [1:0]  wrIdx = '0;
  logic [15:0] wrData = '0;
  logic        reqValid = 1'b0;
  logic [1:0]  reqPtr = '0;
  logic [1:0]  reqMod = '0;
  logic        reqPre = 1'b0;
  logic        bankSwap = 1'b0;
  logic        addrValid;
  logic [23:0] addrOut;
  logic        activeBank;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [15:0] mPtr  [2][4];
  logic [15:0] mMod  [2][4];
  logic [15:0] mLen  [2][4];
  logic [15:0] mBase [2][4];
  logic [7:0]  mPage [2];
  logic        mBank;
  logic [23:0] mAddr;
  logic        mValid;

  always #2 clk = ~clk;

  circ_agen u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrKind(wrKind), .wrIdx(wrIdx),
    .wrData(wrData), .reqValid(reqValid), .reqPtr(reqPtr), .reqMod(reqMod),
    .reqPre(reqPre), .bankSwap(bankSwap), .addrValid(addrValid),
    .addrOut(addrOut), .activeBank(activeBank)
  );

  function automatic logic [15:0] stepModel(logic [15:0] p, logic [15:0] m,
                                            logic [15:0] b, logic [15:0] l);
    int s;
    s = int'(p) + int'($signed(m));
    if (l != 16'd0) begin
      if (s < int'(b)) s = s + int'(l);
      else if (s >= int'(b) + int'(l)) s = s - int'(l);
    end
    return s[15:0];
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(bit wE, logic [2:0] wK, logic [1:0] wI, logic [15:0] wD,
                     bit rV, logic [1:0] rP, logic [1:0] rM, bit rPre, bit sw,
                     string tag);
    logic [15:0] nxt;
    logic b;
    wrEn = wE; wrKind = wK; wrIdx = wI; wrData = wD;
    reqValid = rV; reqPtr = rP; reqMod = rM; reqPre = rPre; bankSwap = sw;
    b = mBank;
    nxt = stepModel(mPtr[b][rP], mMod[b][rM], mBase[b][rP], mLen[b][rP]);
    if (rV) begin
      mAddr = {mPage[b], (rPre ? nxt : mPtr[b][rP])};
      mPtr[b][rP] = nxt;
    end
    mValid = rV;
    if (wE) begin
      case (wK)
        3'd0: mPtr[b][wI]  = wD;
        3'd1: mMod[b][wI]  = wD;
        3'd2: mLen[b][wI]  = wD;
        3'd3: mBase[b][wI] = wD;
        3'd4: mPage[b]     = wD[7:0];
        default: ;
      endcase
    end
    if (sw) mBank = ~mBank;
    @(posedge clk);
    #1;
    wrEn = 1'b0; reqValid = 1'b0; bankSwap = 1'b0;
    check({tag, " R3 valid"}, 32'(addrValid), 32'(mValid));
    check({tag, " addr"}, 32'(addrOut), 32'(mAddr));
    check({tag, " R9 bank"}, 32'(activeBank), 32'(mBank));
  endtask

  task automatic wr(logic [2:0] k, logic [1:0] i, logic [15:0] d, string tag);
    cyc(1'b1, k, i, d, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0, tag);
  endtask

  task automatic acc(logic [1:0] p, logic [1:0] m, bit pre, string tag);
    cyc(1'b0, 3'd0, 2'd0, 16'd0, 1'b1, p, m, pre, 1'b0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int b = 0; b < 2; b++) begin
      for (int i = 0; i < 4; i++) begin
        mPtr[b][i] = '0; mMod[b][i] = '0; mLen[b][i] = '0; mBase[b][i] = '0;
      end
      mPage[b] = '0;
    end
    mBank = 1'b0; mAddr = '0; mValid = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 valid", 32'(addrValid), 32'd0);
    check("R1 addr", 32'(addrOut), 32'd0);
    check("R1 bank", 32'(activeBank), 32'd0);
    rstN = 1'b1;
    @(posedge clk); #1;
    acc(2'd2, 2'd3, 1'b1, "R1 zero regs");
    check("R1 zero access", 32'(addrOut), 32'h0);

    // linear overflow at page top, page preserved
    wr(3'd4, 2'd0, 16'h0012, "R2 page");
    wr(3'd0, 2'd0, 16'hFFFE, "R2 ptr");
    wr(3'd1, 2'd1, 16'h0003, "R2 mod");
    acc(2'd0, 2'd1, 1'b0, "R4 post");
    check("R4 post addr", 32'(addrOut), 32'h12FFFE);
    acc(2'd0, 2'd1, 1'b0, "R6 linear");
    check("R6 R8 overflow addr", 32'(addrOut), 32'h120001);

    // circular wrap both directions
    wr(3'd0, 2'd1, 16'h0100, "R2 ptr1");
    wr(3'd3, 2'd1, 16'h0100, "R2 base1");
    wr(3'd2, 2'd1, 16'h0010, "R2 len1");
    wr(3'd1, 2'd2, 16'hFFFD, "R2 mod2");
    wr(3'd1, 2'd3, 16'h0005, "R2 mod3");
    acc(2'd1, 2'd2, 1'b1, "R5 pre");
    check("R5 R7 low wrap", 32'(addrOut), 32'h12010D);
    acc(2'd1, 2'd3, 1'b1, "R7 high");
    check("R7 high wrap", 32'(addrOut), 32'h120102);

    // ignored kinds
    wr(3'd5, 2'd1, 16'hBEEF, "R2 kind5");
    wr(3'd7, 2'd0, 16'hBEEF, "R2 kind7");
    acc(2'd1, 2'd0, 1'b0, "R2 ignored");
    check("R2 ptr1 unchanged", 32'(addrOut), 32'h120102);

    // write wins over update
    cyc(1'b1, 3'd0, 2'd1, 16'h0108, 1'b1, 2'd1, 2'd3, 1'b0, 1'b0, "R10 same");
    acc(2'd1, 2'd0, 1'b0, "R10 after");
    check("R10 write wins", 32'(addrOut), 32'h120108);

    // independence
    acc(2'd0, 2'd1, 1'b0, "R11 ptr0");
    acc(2'd1, 2'd0, 1'b0, "R11 ptr1");
    check("R11 ptr1 unchanged", 32'(addrOut), 32'h120108);

    // bank swap: same-cycle access and write use old bank
    cyc(1'b1, 3'd0, 2'd3, 16'h0077, 1'b1, 2'd1, 2'd0, 1'b0, 1'b1, "R9 swap");
    check("R9 old bank addr", 32'(addrOut), 32'h120108);
    acc(2'd3, 2'd0, 1'b0, "R9 new bank");
    check("R9 new bank zero", 32'(addrOut), 32'h0);
    wr(3'd0, 2'd3, 16'h0555, "R9 bank1 write");
    cyc(1'b0, 3'd0, 2'd0, 16'd0, 1'b0, 2'd0, 2'd0, 1'b0, 1'b1, "R9 swap back");
    acc(2'd3, 2'd0, 1'b0, "R9 bank0 kept");
    check("R9 bank0 value", 32'(addrOut), 32'h120077);

    // constrained random
    for (int n = 0; n < 3000; n++) begin
      bit wE, rV, sw;
      logic [2:0] wK;
      logic [15:0] wD;
      int mag;
      wE = ($urandom % 3) == 0;
      rV = ($urandom % 4) != 0;
      sw = ($urandom % 16) == 0;
      wK = 3'($urandom % 6);
      case (wK)
        3'd0: wD = 16'(32 + $urandom % 48);
        3'd1: begin
          mag = int'($urandom % 12);
          wD = (($urandom % 2) != 0) ? 16'(-mag) : 16'(mag);
        end
        3'd2: wD = (($urandom % 4) == 0) ? 16'd0 : 16'(12 + $urandom % 20);
        3'd3: wD = 16'(32 + $urandom % 16);
        default: wD = 16'($urandom);
      endcase
      cyc(wE, wK, 2'($urandom), wD, rV, 2'($urandom), 2'($urandom),
          1'($urandom), sw, "R7 random");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule